// File: doc/BRIEF.md
# Receive Frame Buffer Formatter

This block sits between a receive byte stream and a paged packet memory. When a frame's first byte arrives with its declared length, the block decides whether to take the frame. If it takes it, the block claims a free page and writes a fixed image into that page: a status word, a stored byte count, the frame data, zero fill for short frames, an optional CRC-32 and a closing control word. It then hands the page number to the receive queue and signals the receive interrupt source. A refused frame is still consumed from the stream, but it leaves no trace in memory.

Software later walks the page image. The byte count tells it how far the image extends. The closing control word tells it whether one data byte sits after the CRC. All arithmetic, padding and CRC generation run at one byte per clock, and the input is held off while the fixed header and trailer bytes are written.

Top module: `rx_frame_fmt`

## Requirements
- R1: A frame whose first beat arrives while `cfg_rx_on` is 0 or `cfg_soft_rst` is 1 is refused. Refused means `frame_drop` pulses for one cycle, all beats of the frame are consumed, and no page claim, buffer write, queue push or receive event occurs.
- R2: A frame is likewise refused when `page_avail` is 0 at its first beat.
- R3: The stored byte count is computed as follows. Start with 64 when the length L is below 64, otherwise with L rounded down to even. Add 6, then add 4 more when `cfg_strip_crc` is 0. It is written little-endian at page bytes 2 (low) and 3 (high). A frame whose count would exceed 2048 is refused as in R1, and so is a frame with L equal to 0. The number of buffer writes per frame equals the count.
- R4: Page bytes 0 (low) and 1 (high) hold the status word. Bit 11 is set when L > 1518, bit 12 is set when L is odd, and all other bits are 0.
- R5: Frame bytes 0 to E-1, where E is L rounded down to even, are stored at page offsets 4 to E+3. On back-to-back writes, each address is one above the previous one.
- R6: When L < 64, the odd last byte (if any) follows at offset L+3. Zero bytes then fill up to offset 67, and the frame counts as 64 bytes long from then on.
- R7: When `cfg_strip_crc` is 0, four CRC bytes follow the data or padding, least significant byte first. The CRC uses reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. It covers the frame bytes plus any zero padding. When `cfg_strip_crc` is 1, no CRC bytes are written.
- R8: The last two bytes written are the frame's final byte followed by 0x60 when the padded length is odd, or 0x00 followed by 0x40 when it is even.
- R9: One cycle after the last buffer write, `rxq_push` and `rcv_event` pulse together for one cycle. `rxq_page` then equals the `page_id` that was present when the page was claimed.
- R10: `page_take` is high in the cycle that the first beat is decided. The four header bytes are written in the next four cycles with `s_ready` low. The first beat is consumed in the fifth cycle after the claim, and exactly L beats are taken per frame.
- R11: While `rst_n` is low, `s_ready`, `page_take`, `buf_we`, `rxq_push`, `rcv_event` and `frame_drop` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rx_on | input | 1 | Receive enable |
| cfg_soft_rst | input | 1 | Soft reset in progress; refuses frames |
| cfg_strip_crc | input | 1 | 1: omit CRC bytes from the page image |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte taken at this edge |
| s_data | input | 8 | Input byte |
| s_len | input | LEN_W | Frame length in bytes, held for the whole frame |
| page_avail | input | 1 | Allocator has a free page |
| page_id | input | PAGE_W | Number of the free page |
| page_take | output | 1 | Claims `page_id` this cycle |
| buf_we | output | 1 | Packet memory byte write |
| buf_page | output | PAGE_W | Page being written |
| buf_addr | output | PAGE_AW | Byte offset within the page |
| buf_wdata | output | 8 | Byte written |
| rxq_push | output | 1 | Append `rxq_page` to the receive queue |
| rxq_page | output | PAGE_W | Page number pushed |
| rcv_event | output | 1 | Sets the receive interrupt bit |
| frame_drop | output | 1 | Frame refused |

## Verification
The page claim or refusal appears in the same cycle the first beat is presented. Header writes follow in the next four cycles, and the first data beat is taken in the fifth. Padding, CRC and trailer bytes come on consecutive cycles after the last beat, and the queue push comes exactly one cycle after the final write. The bench drives inputs on the falling edge and samples every output one nanosecond later. It records the cycle number of the claim, the first accepted beat, the last write and the push, and checks those spacings directly. After each frame, an 80-cycle settle window covers the longest possible tail. Only then does the bench compare the captured page image against an image built from the requirements.

// File: rtl/rxf_pkg.sv
// Package: shared types and the byte-wise CRC-32 step for the receive
// frame formatter. Assumes the reflected CRC-32 convention.
package rxf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_PAD,
        ST_CRC,
        ST_TRL,
        ST_DONE,
        ST_DRAIN
    } rxf_state_e;

    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam int          ST_LONG_BIT = 11;
    localparam int          ST_ODD_BIT  = 12;
    localparam logic [7:0]  TRL_ODD   = 8'h60;
    localparam logic [7:0]  TRL_EVEN  = 8'h40;
    localparam int          HDR_BYTES = 4;

    // Advance a reflected CRC-32 register by one input byte.
    function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                             input logic [7:0]  d);
        logic [31:0] c;
        c = c_in ^ {24'd0, d};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_len_calc.sv
// Length calculator: turns the declared frame length into the stored byte
// count, the status word, a fits-in-page flag and a short-frame flag.
// Purely combinational; assumes len is stable while it is used.
module rxf_len_calc
    import rxf_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048,
    parameter int MIN_FRAME  = 64,
    parameter int STD_MAX    = 1518
) (
    input  logic [LEN_W-1:0] len,
    input  logic             strip,
    output logic [15:0]      byte_cnt,
    output logic [15:0]      status,
    output logic             fits,
    output logic             is_short
);
    localparam int CW = LEN_W + 2;

    logic [LEN_W-1:0] base;
    logic [CW-1:0]    cnt_w;

    // Compute padded base length, total count and the accept limit.
    always_comb begin
        is_short = len < LEN_W'(MIN_FRAME);
        base     = is_short ? LEN_W'(MIN_FRAME) : {len[LEN_W-1:1], 1'b0};
        cnt_w    = {2'b00, base} + CW'(HDR_BYTES + 2) + (strip ? CW'(0) : CW'(4));
        fits     = (cnt_w <= CW'(PAGE_BYTES)) && (len != '0);
        byte_cnt = 16'(cnt_w);
    end

    // Build the status word from length class and parity.
    always_comb begin
        status              = '0;
        status[ST_LONG_BIT] = len > LEN_W'(STD_MAX);
        status[ST_ODD_BIT]  = len[0];
    end

endmodule

// File: rtl/rxf_crc32.sv
// CRC-32 accumulator: one byte per enabled cycle, cleared to all ones.
// Output is the inverted (final) value of the current register.
module rxf_crc32
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);
    logic [31:0] crc_q;

    // Hold, clear or advance the running CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (clr) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc_step(crc_q, din);
        end
    end

    // Present the finished (inverted) CRC.
    always_comb crc_out = ~crc_q;

endmodule

// File: rtl/rxf_fmt_ctrl.sv
// Formatter sequencer: decides accept/refuse on the first beat, then writes
// header, data, padding, CRC and trailer into the claimed page one byte per
// cycle, and finally pushes the page. Assumes s_len is held for the whole
// frame and that the allocator reflects page_take on the following cycle.
module rxf_fmt_ctrl
    import rxf_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int PAGE_AW   = 11,
    parameter int PAGE_W    = 2,
    parameter int MIN_FRAME = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_rx_on,
    input  logic               cfg_soft_rst,
    input  logic               cfg_strip_crc,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [7:0]         s_data,
    input  logic [LEN_W-1:0]   s_len,
    input  logic [15:0]        calc_cnt,
    input  logic [15:0]        calc_status,
    input  logic               calc_fits,
    input  logic               calc_short,
    input  logic               page_avail,
    input  logic [PAGE_W-1:0]  page_id,
    output logic               page_take,
    output logic               crc_clr,
    output logic               crc_en,
    output logic [7:0]         crc_din,
    input  logic [31:0]        crc_val,
    output logic               buf_we,
    output logic [PAGE_W-1:0]  buf_page,
    output logic [PAGE_AW-1:0] buf_addr,
    output logic [7:0]         buf_wdata,
    output logic               rxq_push,
    output logic [PAGE_W-1:0]  rxq_page,
    output logic               rcv_event,
    output logic               frame_drop
);
    rxf_state_e         state;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   idx;
    logic [15:0]        cnt_q;
    logic [15:0]        stat_q;
    logic               short_q;
    logic               strip_q;
    logic [PAGE_W-1:0]  page_q;
    logic [PAGE_AW-1:0] wptr;
    logic [1:0]         sub;
    logic [7:0]         odd_q;

    logic accept;
    logic last_beat;
    logic tail_odd;
    logic odd_long;
    logic pad_last;

    // Decode frame position and accept conditions.
    always_comb begin
        accept    = s_valid && cfg_rx_on && !cfg_soft_rst && page_avail && calc_fits;
        last_beat = (idx == len_q - 1'b1);
        tail_odd  = len_q[0] && last_beat;
        odd_long  = len_q[0] && !short_q;
        pad_last  = (idx == LEN_W'(MIN_FRAME - 1));
    end

    // Drive handshake, claim, CRC feed and buffer write signals.
    always_comb begin
        s_ready    = (state == ST_DATA) || (state == ST_DRAIN);
        page_take  = (state == ST_IDLE) && accept;
        frame_drop = (state == ST_IDLE) && s_valid && !accept;
        crc_clr    = page_take;
        crc_en     = ((state == ST_DATA) && s_valid) || (state == ST_PAD);
        crc_din    = (state == ST_DATA) ? s_data : 8'h00;
        buf_page   = page_q;
        buf_addr   = wptr;
        rxq_page   = page_q;
        rxq_push   = (state == ST_DONE);
        rcv_event  = (state == ST_DONE);
        buf_we     = 1'b0;
        buf_wdata  = 8'h00;
        unique case (state)
            ST_HDR: begin
                buf_we = 1'b1;
                unique case (wptr[1:0])
                    2'd0: buf_wdata = stat_q[7:0];
                    2'd1: buf_wdata = stat_q[15:8];
                    2'd2: buf_wdata = cnt_q[7:0];
                    default: buf_wdata = cnt_q[15:8];
                endcase
            end
            ST_DATA: begin
                buf_we    = s_valid && (!tail_odd || short_q);
                buf_wdata = s_data;
            end
            ST_PAD: begin
                buf_we    = 1'b1;
                buf_wdata = 8'h00;
            end
            ST_CRC: begin
                buf_we    = 1'b1;
                buf_wdata = crc_val[8*sub +: 8];
            end
            ST_TRL: begin
                buf_we = 1'b1;
                if (sub[0]) buf_wdata = odd_long ? TRL_ODD : TRL_EVEN;
                else        buf_wdata = odd_long ? odd_q : 8'h00;
            end
            default: ;
        endcase
    end

    // Sequence the frame through its phases and track write offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            len_q   <= '0;
            idx     <= '0;
            cnt_q   <= '0;
            stat_q  <= '0;
            short_q <= 1'b0;
            strip_q <= 1'b0;
            page_q  <= '0;
            wptr    <= '0;
            sub     <= '0;
            odd_q   <= '0;
        end else begin
            if (buf_we) wptr <= wptr + 1'b1;
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (s_valid) begin
                        if (accept) begin
                            len_q   <= s_len;
                            cnt_q   <= calc_cnt;
                            stat_q  <= calc_status;
                            short_q <= calc_short;
                            strip_q <= cfg_strip_crc;
                            page_q  <= page_id;
                            wptr    <= '0;
                            state   <= ST_HDR;
                        end else begin
                            len_q <= (s_len == '0) ? LEN_W'(1) : s_len;
                            state <= ST_DRAIN;
                        end
                    end
                end
                ST_HDR: begin
                    if (wptr[1:0] == 2'd3) state <= ST_DATA;
                end
                ST_DATA: begin
                    if (s_valid) begin
                        idx <= idx + 1'b1;
                        if (tail_odd) odd_q <= s_data;
                        if (last_beat) begin
                            sub <= '0;
                            if (short_q)      state <= ST_PAD;
                            else if (strip_q) state <= ST_TRL;
                            else              state <= ST_CRC;
                        end
                    end
                end
                ST_PAD: begin
                    idx <= idx + 1'b1;
                    if (pad_last) begin
                        sub   <= '0;
                        state <= strip_q ? ST_TRL : ST_CRC;
                    end
                end
                ST_CRC: begin
                    sub <= sub + 1'b1;
                    if (sub == 2'd3) state <= ST_TRL;
                end
                ST_TRL: begin
                    sub <= sub + 1'b1;
                    if (sub[0]) state <= ST_DONE;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                ST_DRAIN: begin
                    if (s_valid) begin
                        idx <= idx + 1'b1;
                        if (last_beat) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_frame_fmt.sv
// Top of the receive frame formatter: joins the length calculator, the
// CRC accumulator and the sequencer. Assumes a page holds PAGE_BYTES bytes.
module rx_frame_fmt #(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048,
    parameter int PAGE_W     = 2,
    parameter int MIN_FRAME  = 64,
    parameter int STD_MAX    = 1518,
    parameter int PAGE_AW    = $clog2(PAGE_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_rx_on,
    input  logic               cfg_soft_rst,
    input  logic               cfg_strip_crc,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [7:0]         s_data,
    input  logic [LEN_W-1:0]   s_len,
    input  logic               page_avail,
    input  logic [PAGE_W-1:0]  page_id,
    output logic               page_take,
    output logic               buf_we,
    output logic [PAGE_W-1:0]  buf_page,
    output logic [PAGE_AW-1:0] buf_addr,
    output logic [7:0]         buf_wdata,
    output logic               rxq_push,
    output logic [PAGE_W-1:0]  rxq_page,
    output logic               rcv_event,
    output logic               frame_drop
);
    logic [15:0] calc_cnt;
    logic [15:0] calc_status;
    logic        calc_fits;
    logic        calc_short;
    logic        crc_clr;
    logic        crc_en;
    logic [7:0]  crc_din;
    logic [31:0] crc_val;

    rxf_len_calc #(
        .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
        .MIN_FRAME(MIN_FRAME), .STD_MAX(STD_MAX)
    ) u_len (
        .len(s_len), .strip(cfg_strip_crc),
        .byte_cnt(calc_cnt), .status(calc_status),
        .fits(calc_fits), .is_short(calc_short)
    );

    rxf_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(crc_din), .crc_out(crc_val)
    );

    rxf_fmt_ctrl #(
        .LEN_W(LEN_W), .PAGE_AW(PAGE_AW), .PAGE_W(PAGE_W), .MIN_FRAME(MIN_FRAME)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_rx_on(cfg_rx_on), .cfg_soft_rst(cfg_soft_rst), .cfg_strip_crc(cfg_strip_crc),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_len(s_len),
        .calc_cnt(calc_cnt), .calc_status(calc_status),
        .calc_fits(calc_fits), .calc_short(calc_short),
        .page_avail(page_avail), .page_id(page_id), .page_take(page_take),
        .crc_clr(crc_clr), .crc_en(crc_en), .crc_din(crc_din), .crc_val(crc_val),
        .buf_we(buf_we), .buf_page(buf_page), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .rxq_push(rxq_push), .rxq_page(rxq_page), .rcv_event(rcv_event),
        .frame_drop(frame_drop)
    );

endmodule

// File: rtl/rxf_chk.sv
// Checker: temporal rules on the formatter's ports, bound to the top.
module rxf_chk #(
    parameter int PAGE_AW = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_ready,
    input logic               page_take,
    input logic               frame_drop,
    input logic               buf_we,
    input logic [PAGE_AW-1:0] buf_addr,
    input logic               rxq_push,
    input logic               rcv_event
);
    // R1
    drop_take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_drop && page_take));

    // R9
    push_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |-> rcv_event);

    // R9
    push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |=> !rxq_push);

    // R10
    hdr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && buf_addr < PAGE_AW'(4)) |-> !s_ready);

    // R10
    take_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_take |=> (buf_we && buf_addr == '0));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && $past(buf_we)) |-> (buf_addr == $past(buf_addr) + 1'b1));
endmodule

bind rx_frame_fmt rxf_chk #(.PAGE_AW(PAGE_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .page_take(page_take),
    .frame_drop(frame_drop), .buf_we(buf_we), .buf_addr(buf_addr),
    .rxq_push(rxq_push), .rcv_event(rcv_event)
);

// File: tb/tb_rx_frame_fmt.sv
`timescale 1ns/100ps
module tb_rx_frame_fmt;
    localparam int LEN_W = 12;
    localparam int PW    = 2;
    localparam int AW    = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rx_on = 1'b0, cfg_soft_rst = 1'b0, cfg_strip_crc = 1'b0;
    logic s_valid = 1'b0;
    logic s_ready;
    logic [7:0] s_data = '0;
    logic [LEN_W-1:0] s_len = '0;
    logic page_avail = 1'b1;
    logic [PW-1:0] page_id = '0;
    logic page_take, buf_we, rxq_push, rcv_event, frame_drop;
    logic [PW-1:0] buf_page, rxq_page;
    logic [AW-1:0] buf_addr;
    logic [7:0] buf_wdata;

    always #2 clk = ~clk;

    rx_frame_fmt dut (
        .clk(clk), .rst_n(rst_n), .cfg_rx_on(cfg_rx_on), .cfg_soft_rst(cfg_soft_rst),
        .cfg_strip_crc(cfg_strip_crc), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_len(s_len), .page_avail(page_avail), .page_id(page_id),
        .page_take(page_take), .buf_we(buf_we), .buf_page(buf_page),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .rxq_push(rxq_push),
        .rxq_page(rxq_page), .rcv_event(rcv_event), .frame_drop(frame_drop)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int n_wr, n_take, n_push, n_evt, n_drop, n_rdy;
    int take_cyc, first_rdy_cyc, last_wr_cyc, push_cyc, push_page;
    logic [7:0] got_img [2048];
    logic [7:0] exp_img [2048];
    int         exp_rg  [2048];
    int         exp_total;

    // {strip, length}
    localparam logic [12:0] VEC [11] = '{
        {1'b0, 12'd60},   {1'b0, 12'd61},   {1'b1, 12'd1},    {1'b1, 12'd63},
        {1'b0, 12'd64},   {1'b0, 12'd65},   {1'b1, 12'd100},  {1'b0, 12'd1518},
        {1'b0, 12'd1519}, {1'b0, 12'd2038}, {1'b1, 12'd2043}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Monitor: sample outputs 1 ns after the falling edge.
    always begin
        @(negedge clk); #1;
        if (rst_n) begin
            if (buf_we) begin
                got_img[buf_addr] = buf_wdata; n_wr++; last_wr_cyc = cyc;
            end
            if (page_take) begin n_take++; take_cyc = cyc; end
            if (s_ready && s_valid && first_rdy_cyc < 0) first_rdy_cyc = cyc;
            if (s_ready) n_rdy++;
            if (rxq_push) begin n_push++; push_cyc = cyc; push_page = int'(rxq_page); end
            if (rcv_event) n_evt++;
            if (frame_drop) n_drop++;
        end
    end

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((i * 7 + seed * 29 + 3) ^ (i >> 8));
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic build_exp(int len, bit strip, int seed);
        int p, ev, eff;
        logic [15:0] st, bc;
        logic [31:0] c;
        logic [7:0] b;
        st = 16'((len > 1518 ? 16'h0800 : 16'h0) | (len % 2 == 1 ? 16'h1000 : 16'h0));
        bc = 16'(((len < 64) ? 64 : (len & ~1)) + 6 + (strip ? 0 : 4));
        exp_img[0] = st[7:0]; exp_img[1] = st[15:8]; exp_rg[0] = 0; exp_rg[1] = 0;
        exp_img[2] = bc[7:0]; exp_img[3] = bc[15:8]; exp_rg[2] = 1; exp_rg[3] = 1;
        ev = len & ~1;
        for (int i = 0; i < ev; i++) begin exp_img[4+i] = pat(seed, i); exp_rg[4+i] = 2; end
        p = 4 + ev;
        if (len < 64) begin
            if (len % 2 == 1) begin exp_img[p] = pat(seed, len-1); exp_rg[p] = 3; p++; end
            while (p < 68) begin exp_img[p] = 8'h00; exp_rg[p] = 3; p++; end
        end
        eff = (len < 64) ? 64 : len;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < eff; i++) begin
            b = (i < len) ? pat(seed, i) : 8'h00;
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB88320;
                else             c = c >> 1;
            end
        end
        c = ~c;
        if (!strip) begin
            for (int k = 0; k < 4; k++) begin exp_img[p] = c[8*k +: 8]; exp_rg[p] = 4; p++; end
        end
        if (eff % 2 == 1) begin exp_img[p] = pat(seed, len-1); exp_img[p+1] = 8'h60; end
        else              begin exp_img[p] = 8'h00;            exp_img[p+1] = 8'h40; end
        exp_rg[p] = 5; exp_rg[p+1] = 5;
        exp_total = p + 2;
    endtask

    task automatic send(int len, bit strip, int seed, int pg, bit avail);
        int n;
        bit rdy;
        n_wr = 0; n_take = 0; n_push = 0; n_evt = 0; n_drop = 0; n_rdy = 0;
        take_cyc = -1; first_rdy_cyc = -1; last_wr_cyc = -1; push_cyc = -1; push_page = -1;
        for (int a = 0; a < 2048; a++) got_img[a] = 8'hxx;
        n = (len == 0) ? 1 : len;
        @(negedge clk);
        cfg_strip_crc = strip; page_avail = avail; page_id = PW'(pg);
        for (int i = 0; i < n; ) begin
            s_valid = 1'b1; s_data = pat(seed, i); s_len = LEN_W'(len);
            #1 rdy = s_ready;
            @(negedge clk);
            if (rdy) i++;
        end
        s_valid = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    task automatic check_ok(int len, bit strip, int seed, int pg);
        string names [6] = '{"R4 status", "R3 count", "R5 data", "R6 pad", "R7 crc", "R8 trailer"};
        build_exp(len, strip, seed);
        chk(n_wr == exp_total, "R3", "write count", n_wr, exp_total);
        for (int r = 0; r < 6; r++) begin
            bit bad = 0; int ba = 0; int act = 0; int ex = 0; bit any = 0;
            for (int a = 0; a < exp_total; a++) begin
                if (exp_rg[a] == r) begin
                    any = 1;
                    if (!bad && got_img[a] !== exp_img[a]) begin
                        bad = 1; ba = a; act = int'(got_img[a]); ex = int'(exp_img[a]);
                    end
                end
            end
            if (any) chk(!bad, names[r], $sformatf("len %0d byte %0d", len, ba), act, ex);
        end
        chk(n_take == 1 && n_drop == 0, "R1", "claim without drop", n_take, 1);
        chk(n_push == 1 && push_page == pg, "R9", "pushed page", push_page, pg);
        chk(n_evt == 1 && push_cyc == last_wr_cyc + 1, "R9", "push timing", push_cyc, last_wr_cyc + 1);
        chk(first_rdy_cyc == take_cyc + 5, "R10", "first beat cycle", first_rdy_cyc, take_cyc + 5);
        chk(n_rdy == len, "R10", "beats taken", n_rdy, len);
    endtask

    task automatic check_rej(string req, int len);
        int n;
        n = (len == 0) ? 1 : len;
        chk(n_drop == 1 && n_take == 0, req, "refusal pulse", n_drop, 1);
        chk(n_wr == 0 && n_push == 0 && n_evt == 0, req, "no writes or push", n_wr + n_push, 0);
        chk(n_rdy == n, req, "beats drained", n_rdy, n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        chk(!s_ready && !buf_we && !page_take && !rxq_push && !rcv_event && !frame_drop,
            "R11", "outputs in reset",
            int'({s_ready, buf_we, page_take, rxq_push, rcv_event, frame_drop}), 0);
        @(negedge clk);
        rst_n = 1'b1; cfg_rx_on = 1'b1;
        repeat (2) @(negedge clk);

        foreach (VEC[v]) begin
            send(int'(VEC[v][11:0]), VEC[v][12], v, v % 4, 1'b1);
            check_ok(int'(VEC[v][11:0]), VEC[v][12], v, v % 4);
        end

        // R1 receive disabled
        cfg_rx_on = 1'b0;
        send(70, 1'b0, 20, 1, 1'b1); check_rej("R1", 70);
        cfg_rx_on = 1'b1;
        // R1 soft reset active
        cfg_soft_rst = 1'b1;
        send(70, 1'b0, 21, 1, 1'b1); check_rej("R1", 70);
        cfg_soft_rst = 1'b0;
        // R2 no free page
        send(80, 1'b1, 22, 2, 1'b0); check_rej("R2", 80);
        // R3 count over page size, CRC kept and stripped
        send(2044, 1'b0, 23, 0, 1'b1); check_rej("R3", 2044);
        send(2045, 1'b1, 24, 0, 1'b1); check_rej("R3", 2045);
        // R3 zero length
        send(0, 1'b0, 25, 0, 1'b1); check_rej("R3", 0);
        // R1 recovery after refusals
        send(65, 1'b1, 26, 3, 1'b1); check_ok(65, 1'b1, 26, 3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule